// File: doc/BRIEF.md
# Decimating Pixel Capture Sequencer

This block drives the pixel clock of an image sensor after the sensor has been told to begin an exposure. It first toggles the sensor clock and watches the sensor's ready line, then issues a single lead-in pulse. After that it walks the sensor's row-major pixel stream, one clock pulse per pixel. From that stream it keeps every fourth pixel of every fourth row and stores the 6-bit converter value of each kept pixel into an external image buffer, so the buffer ends up holding a 32x32 thumbnail of a 128-pixel-wide frame.

A capture begins with a one-cycle `start` pulse. Every sensor clock pulse lasts two system cycles, one high and one low. Buffer writes fall into the low half of a pulse, and each kept sample gets exactly one write strobe. The capture stops once the last buffer location has been written, and `done` pulses at that point. If the sensor never reports ready, a pulse budget runs out and the block raises `waitTimeout` instead, then returns to idle.

Top module: `pixel_decim_capture`

## Requirements
- R1: After reset, and while idle, `sensClk`, `bufWe`, `done` and `waitTimeout` are all low.
- R2: After `start`, the block emits sensor clock pulses and samples `readIn` during the high half of each one. It keeps pulsing until `readIn` is seen high.
- R3: Once ready has been seen, exactly one further pulse is issued and no pixel is taken from it. The pulse after that carries pixel 0 of row 0.
- R4: Pixel pulses are numbered q = 0, 1, 2, … from the first pixel pulse. With row = q / 128 and column = q % 128, a pixel is kept only when column % 4 == 0 and row % 4 == 0. `pixIn` is sampled during the high half of that pulse.
- R5: Each kept row yields 32 samples. The three rows of 128 pulses that follow a kept row are clocked but never written.
- R6: Kept samples are written to `bufAddr` 0, 1, 2, … in order. `bufData` equals the 6-bit `pixIn` value of the corresponding pulse.
- R7: `bufWe` is high for exactly one system cycle per kept sample, and only while `sensClk` is low.
- R8: The capture ends after the write to address 1023, with no further sensor pulses. `done` is high for exactly one cycle, in the cycle that follows that write.
- R9: If `readIn` stays low for WAIT_LIMIT pulses, `waitTimeout` pulses for one cycle and no buffer write occurs. The block then returns to idle and accepts a new `start`. Ready seen on the last allowed pulse still starts readout.
- R10: A `start` pulse that arrives during a capture is ignored; the running capture continues unchanged.
- R11: The high half of every sensor pulse lasts exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a capture |
| readIn | input | 1 | Sensor ready indication |
| pixIn | input | 6 | Converter output for the current pixel |
| sensClk | output | 1 | Clock to the sensor |
| bufAddr | output | 10 | Image buffer write address |
| bufData | output | 6 | Image buffer write data |
| bufWe | output | 1 | Image buffer write strobe |
| done | output | 1 | One-cycle capture-complete pulse |
| waitTimeout | output | 1 | One-cycle pulse when ready never arrives |

## Verification
The checker enforces the properties that hold on every cycle. Writes occur only while the sensor clock is low and last a single cycle. Write addresses advance by one from zero. The sensor clock stays high for only one cycle at a time. `done` is a single-cycle pulse that directly follows the write to the top address. Which pixels are kept can only be shown by the bench scenarios. The bench drives a modelled sensor whose pixel value depends on the pulse number, so those scenarios show the kept-pixel selection, the single lead-in pulse, the three skipped rows and the total pulse count at termination. They also cover the timeout and restart paths and the ready-on-last-pulse boundary.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_H,
    ST_WAIT_L,
    ST_LEAD_H,
    ST_LEAD_L,
    ST_PIX_H,
    ST_PIX_L,
    ST_DONE,
    ST_ABORT
  } seqState_t;

  typedef struct packed {
    logic clrAll;    // new capture: zero every counter
    logic waitInc;   // one more ready-wait pulse spent
    logic sampleEn;  // capture pixIn into the sample register
    logic writeEn;   // write the held sample to the buffer
    logic advance;   // one pixel pulse completed
  } seqStrobe_t;

endpackage

// File: rtl/pdc_datapath.sv
module pdc_datapath
  import pdc_pkg::*;
#(
  parameter int PIX_W      = 6,
  parameter int ROW_LEN    = 128,
  parameter int DECIM      = 4,
  parameter int ADDR_W     = 10,
  parameter int WAIT_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [PIX_W-1:0]  pixIn,
  output logic              keepNow,
  output logic              lastAddr,
  output logic              waitExpired,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [PIX_W-1:0]  bufData,
  output logic              bufWe
);

  localparam int COL_W = $clog2(ROW_LEN);
  localparam int DEC_W = $clog2(DECIM);
  localparam int WAIT_W = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(ROW_LEN - 1);
  localparam logic [DEC_W-1:0]  ROW_LAST  = DEC_W'(DECIM - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LIMIT - 1);

  logic [COL_W-1:0]  colCnt;
  logic [DEC_W-1:0]  rowPhase;
  logic [ADDR_W-1:0] addr;
  logic [WAIT_W-1:0] waitCnt;
  logic [PIX_W-1:0]  sample;

  // Column / row-phase position within the pixel stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt   <= '0;
      rowPhase <= '0;
    end else if (stb.clrAll) begin
      colCnt   <= '0;
      rowPhase <= '0;
    end else if (stb.advance) begin
      if (colCnt == COL_LAST) begin
        colCnt   <= '0;
        rowPhase <= (rowPhase == ROW_LAST) ? '0 : rowPhase + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  // Buffer address counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (stb.clrAll) begin
      addr <= '0;
    end else if (stb.writeEn) begin
      addr <= addr + 1'b1;
    end
  end

  // Ready-wait pulse budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (stb.clrAll) begin
      waitCnt <= '0;
    end else if (stb.waitInc) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  // Pixel sample register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sample <= '0;
    end else if (stb.sampleEn) begin
      sample <= pixIn;
    end
  end

  assign keepNow     = (colCnt[DEC_W-1:0] == '0) && (rowPhase == '0);
  assign lastAddr    = (addr == ADDR_LAST);
  assign waitExpired = (waitCnt == WAIT_LAST);
  assign bufAddr     = addr;
  assign bufData     = sample;
  assign bufWe       = stb.writeEn;

endmodule

// File: rtl/pdc_control.sv
module pdc_control
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       readIn,
  input  logic       keepNow,
  input  logic       lastAddr,
  input  logic       waitExpired,
  output seqStrobe_t stb,
  output logic       sensClk,
  output logic       done,
  output logic       waitTimeout
);

  seqState_t state, nextState;
  logic      readSeen;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.clrAll = 1'b1;
          nextState  = ST_WAIT_H;
        end
      end
      ST_WAIT_H: nextState = ST_WAIT_L;
      ST_WAIT_L: begin
        if (readSeen) begin
          nextState = ST_LEAD_H;
        end else if (waitExpired) begin
          nextState = ST_ABORT;
        end else begin
          stb.waitInc = 1'b1;
          nextState   = ST_WAIT_H;
        end
      end
      ST_LEAD_H: nextState = ST_LEAD_L;
      ST_LEAD_L: nextState = ST_PIX_H;
      ST_PIX_H: begin
        stb.sampleEn = keepNow;
        nextState    = ST_PIX_L;
      end
      ST_PIX_L: begin
        stb.advance = 1'b1;
        stb.writeEn = keepNow;
        nextState   = (keepNow && lastAddr) ? ST_DONE : ST_PIX_H;
      end
      ST_DONE:  nextState = ST_IDLE;
      ST_ABORT: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sensClk  <= 1'b0;
      readSeen <= 1'b0;
    end else begin
      state    <= nextState;
      sensClk  <= (nextState == ST_WAIT_H) || (nextState == ST_LEAD_H) ||
                  (nextState == ST_PIX_H);
      if (state == ST_WAIT_H) begin
        readSeen <= readIn;
      end else if (state == ST_IDLE) begin
        readSeen <= 1'b0;
      end
    end
  end

  assign done        = (state == ST_DONE);
  assign waitTimeout = (state == ST_ABORT);

endmodule

// File: rtl/pixel_decim_capture.sv
module pixel_decim_capture
  import pdc_pkg::*;
#(
  parameter int PIX_W      = 6,
  parameter int ROW_LEN    = 128,
  parameter int DECIM      = 4,
  parameter int ADDR_W     = 10,
  parameter int WAIT_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              readIn,
  input  logic [PIX_W-1:0]  pixIn,
  output logic              sensClk,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [PIX_W-1:0]  bufData,
  output logic              bufWe,
  output logic              done,
  output logic              waitTimeout
);

  seqStrobe_t stb;
  logic       keepNow;
  logic       lastAddr;
  logic       waitExpired;

  pdc_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .readIn      (readIn),
    .keepNow     (keepNow),
    .lastAddr    (lastAddr),
    .waitExpired (waitExpired),
    .stb         (stb),
    .sensClk     (sensClk),
    .done        (done),
    .waitTimeout (waitTimeout)
  );

  pdc_datapath #(
    .PIX_W      (PIX_W),
    .ROW_LEN    (ROW_LEN),
    .DECIM      (DECIM),
    .ADDR_W     (ADDR_W),
    .WAIT_LIMIT (WAIT_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .pixIn       (pixIn),
    .keepNow     (keepNow),
    .lastAddr    (lastAddr),
    .waitExpired (waitExpired),
    .bufAddr     (bufAddr),
    .bufData     (bufData),
    .bufWe       (bufWe)
  );

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              sensClk,
  input logic              bufWe,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              done,
  input logic              waitTimeout
);

  logic [ADDR_W-1:0] expAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expAddr <= '0;
    end else if (bufWe) begin
      expAddr <= expAddr + 1'b1;
    end
  end

  assert_we_clk_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> !sensClk);

  assert_we_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |=> !bufWe);

  assert_addr_seq_R6: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (bufAddr == expAddr));

  assert_clk_high_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    sensClk |=> !sensClk);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(bufWe) && ($past(bufAddr) == '1)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_timeout_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    waitTimeout |=> !waitTimeout);

  assert_timeout_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    waitTimeout |-> (!bufWe && !done && !sensClk));

endmodule

bind pixel_decim_capture pdc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sensClk     (sensClk),
  .bufWe       (bufWe),
  .bufAddr     (bufAddr),
  .done        (done),
  .waitTimeout (waitTimeout)
);

// File: tb/pixel_decim_capture_tb.sv
module pixel_decim_capture_tb;

  localparam int ROW      = 128;
  localparam int DEC      = 4;
  localparam int PER_ROW  = ROW / DEC;
  localparam int SAMPLES  = 1024;
  localparam int WLIM     = 64;
  localparam int LAST_Q   = (SAMPLES / PER_ROW - 1) * DEC * ROW + (PER_ROW - 1) * DEC;
  localparam int GUARD    = 60000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       readIn;
  logic [5:0] pixIn;
  logic       sensClk;
  logic [9:0] bufAddr;
  logic [5:0] bufData;
  logic       bufWe;
  logic       done;
  logic       waitTimeout;

  int vecCount = 0;
  int failCount = 0;
  int pulseCnt = 0;
  int base = 0;
  int readyAt = 32'h3fffffff;
  int wrCount = 0;
  int doneSeen = 0;
  int toSeen = 0;

  always #5 clk = ~clk;

  function automatic logic [5:0] pixFn(int n);
    return 6'((n ^ (n >> 3) ^ (n >> 7) ^ (n >> 11)) & 63);
  endfunction

  // sensor model: pulse counter, ready line, pixel value per pulse
  always @(posedge sensClk) pulseCnt <= pulseCnt + 1;
  assign readIn = (pulseCnt - base) >= readyAt;
  assign pixIn  = pixFn(pulseCnt);

  pixel_decim_capture #(.WAIT_LIMIT(WLIM)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .readIn(readIn), .pixIn(pixIn),
    .sensClk(sensClk), .bufAddr(bufAddr), .bufData(bufData), .bufWe(bufWe),
    .done(done), .waitTimeout(waitTimeout)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // write monitor: R4, R5, R6, R7 checked on every write
  always @(negedge clk) begin
    if (rstN) begin
      if (bufWe) begin
        automatic int r = wrCount / PER_ROW;
        automatic int c = wrCount % PER_ROW;
        automatic int q = r * DEC * ROW + c * DEC;
        check(bufAddr == 10'(wrCount), "R6", "write address", int'(bufAddr), wrCount);
        check(bufData == pixFn(base + readyAt + 2 + q), "R4_R5_R6", "write data",
              int'(bufData), int'(pixFn(base + readyAt + 2 + q)));
        check(!sensClk, "R7", "sensClk during write", int'(sensClk), 0);
        wrCount++;
      end
      if (done) doneSeen++;
      if (waitTimeout) toSeen++;
    end
  end

  task automatic waitEnd();
    int n = 0;
    while (!(done || waitTimeout) && n < GUARD) begin
      @(negedge clk);
      n++;
    end
    if (n >= GUARD) check(1'b0, "WATCHDOG", "run end", n, GUARD);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runCapture(int rdy, bit restart);
    @(negedge clk);
    base = pulseCnt;
    readyAt = rdy;
    wrCount = 0;
    doneSeen = 0;
    toSeen = 0;
    pulseStart();
    if (restart) begin
      int n = 0;
      while (wrCount < 100 && n < GUARD) begin
        @(negedge clk);
        n++;
      end
      pulseStart();  // R10: must be ignored
    end
    waitEnd();
    repeat (20) @(negedge clk);
    check(wrCount == SAMPLES, "R8", "write count", wrCount, SAMPLES);
    check(doneSeen == 1, "R8", "done cycles", doneSeen, 1);
    check(toSeen == 0, "R9", "timeout during capture", toSeen, 0);
    check(pulseCnt - base == rdy + 2 + LAST_Q, "R3_R8", "total sensor pulses",
          pulseCnt - base, rdy + 2 + LAST_Q);
    if (restart) check(wrCount == SAMPLES, "R10", "restart ignored", wrCount, SAMPLES);
    check(!sensClk && !bufWe && !done, "R1", "idle after capture",
          int'({sensClk, bufWe, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!sensClk && !bufWe && !done && !waitTimeout, "R1", "reset outputs",
          int'({sensClk, bufWe, done, waitTimeout}), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(pulseCnt == 0, "R1", "no pulses while idle", pulseCnt, 0);

    // R2, R3: ready on first pulse
    runCapture(1, 1'b0);
    // R2, R10: longer wait, extra start mid-capture
    runCapture(37, 1'b1);

    // R9: ready never arrives
    @(negedge clk);
    base = pulseCnt;
    readyAt = 32'h3fffffff;
    wrCount = 0;
    doneSeen = 0;
    toSeen = 0;
    pulseStart();
    waitEnd();
    repeat (10) @(negedge clk);
    check(toSeen == 1, "R9", "timeout cycles", toSeen, 1);
    check(wrCount == 0, "R9", "writes after timeout", wrCount, 0);
    check(doneSeen == 0, "R9", "done after timeout", doneSeen, 0);
    check(pulseCnt - base == WLIM, "R9", "wait pulses", pulseCnt - base, WLIM);

    // R9 boundary: ready on the last allowed pulse, after an abort
    runCapture(WLIM, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #1900000;
    failCount++;
    $display("FAIL WATCHDOG global timeout: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule